// File: doc/BRIEF.md
# Processor Status Word with Sticky Saturation Tracking

This block holds the 16-bit status word of a small core with DSP extensions. Each cycle it merges ALU flag results, events from two accumulators, loop-engine state and software bus writes into one packed value. It also produces the core's effective interrupt priority level. Half carry is computed inside the block from the ALU operands, for byte-wide or word-wide operations.

Each accumulator has a saturation bit that stays set after a saturation event until software clears it. It also has an overflow bit that only hardware can set. The two summary bits always show the OR of the per-accumulator pairs. Writing zero to the saturation summary position clears both saturation bits at once. A nesting-disable input makes the priority field ignore software writes.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset `sr_value` is 0x0000, and `eff_ipl` equals `{ipl_msb, 3'b000}`.
- R2: When `alu_upd_en` is 1 and there is no low-byte write, bits 3..0 (negative, overflow, zero, carry) take `{alu_n, alu_ov, alu_z, alu_c}` on the next cycle. With neither source active they hold their value.
- R3: When `alu_upd_en` is 1, bit 8 (half carry) takes the carry out of bit 3 of `a + b + cin` if `alu_byte_op` is 1, and the carry out of bit 7 otherwise. Operand bits above that point have no effect.
- R4: Bits 15/14 (accumulator A/B overflow) are set by `acc_ovf_a`/`acc_ovf_b`. A high-byte write of 0 at a bit's position clears it, and a written 1 never sets it.
- R5: Bits 13/12 (accumulator A/B saturation) are set by `acc_sat_a`/`acc_sat_b` and hold until a high-byte write. That write loads each bit with its written value ANDed with written bit 10.
- R6: A high-byte write with bit 10 equal to 0 clears both saturation bits, whatever is written at bits 13 and 12.
- R7: A hardware overflow or saturation event in the same cycle as a clearing write leaves that bit set.
- R8: Bit 11 always reads as bit15 OR bit14, and bit 10 always reads as bit13 OR bit12.
- R9: Bit 9 (loop active) and bit 4 (repeat active) show `loop_do_active` and `loop_rpt_active` one cycle later. Bus writes do not change them.
- R10: When `nest_dis` is 0, a low-byte write loads bits 7..5 (priority) from the written data. When `nest_dis` is 1 those bits keep their value.
- R11: `eff_ipl` is `{ipl_msb, sr_value[7:5]}` and `user_irq_dis` equals `ipl_msb`, with no added cycle of delay.
- R12: Byte enable bit 0 selects the low byte and bit 1 the high byte. A bus write overrides an ALU update to the same bit in the same cycle (flags 3..0 and half carry).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_upd_en | input | 1 | Apply ALU flag results this cycle |
| alu_c | input | 1 | ALU carry result |
| alu_z | input | 1 | ALU zero result |
| alu_ov | input | 1 | ALU overflow result |
| alu_n | input | 1 | ALU negative result |
| alu_op_a | input | DATA_W | ALU first operand, for half carry |
| alu_op_b | input | DATA_W | ALU second operand (already inverted for subtraction) |
| alu_cin | input | 1 | ALU carry into bit 0 |
| alu_byte_op | input | 1 | 1 = byte-wide operation |
| acc_ovf_a | input | 1 | Accumulator A overflow event |
| acc_ovf_b | input | 1 | Accumulator B overflow event |
| acc_sat_a | input | 1 | Accumulator A saturation event |
| acc_sat_b | input | 1 | Accumulator B saturation event |
| loop_do_active | input | 1 | Hardware loop in progress |
| loop_rpt_active | input | 1 | Repeat loop in progress |
| bus_wr_en | input | 1 | Software write strobe |
| bus_byte_en | input | 2 | Byte enables: bit 0 low, bit 1 high |
| bus_wdata | input | 16 | Software write data |
| nest_dis | input | 1 | Nesting disable: priority field read-only |
| ipl_msb | input | 1 | External fourth priority bit |
| sr_value | output | 16 | Packed status word |
| eff_ipl | output | 4 | Effective interrupt priority level |
| user_irq_dis | output | 1 | User interrupts disabled |

## Verification
The bench builds the block with a 16-bit operand width, so the split points for half carry are bits 3 and 7, and it uses the event-wins setting. With these values every low-nibble combination for byte operations can be swept in full. A dense sweep of low-byte combinations covers word operations, with garbage placed in the upper operand bits. All sixteen priority and external-bit combinations are covered, and every combination of saturation and summary bits written by software is reachable in a few cycles.

// File: rtl/cpu_sr_pkg.sv
package cpu_sr_pkg;
   localparam int SR_W        = 16;
   localparam int NUM_ACC     = 2;
   localparam int BIT_OVF_A   = 15;
   localparam int BIT_OVF_B   = 14;
   localparam int BIT_SAT_A   = 13;
   localparam int BIT_SAT_B   = 12;
   localparam int BIT_OVF_ANY = 11;
   localparam int BIT_SAT_ANY = 10;
   localparam int BIT_LOOP    = 9;
   localparam int BIT_HCARRY  = 8;
   localparam int PRIO_W      = 3;
   localparam int BIT_PRIO_LO = 5;
   localparam int BIT_RPT     = 4;
   localparam int FLAG_W      = 4;

   typedef struct packed {
      logic neg;
      logic ovf;
      logic zero;
      logic carry;
   } alu_flags_t;
endpackage

// File: rtl/sr_half_carry.sv
module sr_half_carry #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              cin,
   input  logic              byte_op,
   output logic              hc
);
   localparam int BYTE_SPLIT = DATA_W / 4;
   localparam int WORD_SPLIT = DATA_W / 2;

   if (DATA_W < 8 || (DATA_W % 4) != 0) begin : g_bad_width
      $error("sr_half_carry: DATA_W must be a multiple of 4, at least 8");
   end

   logic [BYTE_SPLIT:0] sum_byte;
   logic [WORD_SPLIT:0] sum_word;

   assign sum_byte = {1'b0, op_a[BYTE_SPLIT-1:0]} + {1'b0, op_b[BYTE_SPLIT-1:0]}
                   + {{BYTE_SPLIT{1'b0}}, cin};
   assign sum_word = {1'b0, op_a[WORD_SPLIT-1:0]} + {1'b0, op_b[WORD_SPLIT-1:0]}
                   + {{WORD_SPLIT{1'b0}}, cin};
   assign hc = byte_op ? sum_byte[BYTE_SPLIT] : sum_word[WORD_SPLIT];

   logic unused_hi;
   assign unused_hi = ^{op_a[DATA_W-1:WORD_SPLIT], op_b[DATA_W-1:WORD_SPLIT]};
endmodule

// File: rtl/sr_sticky_bit.sv
module sr_sticky_bit #(
   parameter bit SW_CAN_SET = 1'b1,
   parameter bit EVENT_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic wr,
   input  logic wval,
   output logic q
);
   logic nxt;

   if (SW_CAN_SET) begin : g_rw
      if (EVENT_WINS) begin : g_evt_first
         assign nxt = evt | (wr ? wval : q);
      end else begin : g_clr_first
         assign nxt = wr ? wval : (q | evt);
      end
   end else begin : g_clear_only
      logic clr;
      assign clr = wr & ~wval;
      if (EVENT_WINS) begin : g_evt_first
         assign nxt = evt | (q & ~clr);
      end else begin : g_clr_first
         assign nxt = ~clr & (q | evt);
      end

      // R4: software can never raise an overflow bit
      a_r4_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
         (!q && !evt) |=> !q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
   end

   // R5: without a write the bit never drops
   a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !wr) |=> q);

   if (EVENT_WINS) begin : g_chk_evt
      // R7: an event beats a same-cycle clear
      a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
         evt |=> q);
   end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
   import cpu_sr_pkg::*;
#(
   parameter int DATA_W         = 16,
   parameter bit SAT_EVENT_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alu_upd_en,
   input  logic              alu_c,
   input  logic              alu_z,
   input  logic              alu_ov,
   input  logic              alu_n,
   input  logic [DATA_W-1:0] alu_op_a,
   input  logic [DATA_W-1:0] alu_op_b,
   input  logic              alu_cin,
   input  logic              alu_byte_op,
   input  logic              acc_ovf_a,
   input  logic              acc_ovf_b,
   input  logic              acc_sat_a,
   input  logic              acc_sat_b,
   input  logic              loop_do_active,
   input  logic              loop_rpt_active,
   input  logic              bus_wr_en,
   input  logic [1:0]        bus_byte_en,
   input  logic [15:0]       bus_wdata,
   input  logic              nest_dis,
   input  logic              ipl_msb,
   output logic [15:0]       sr_value,
   output logic [3:0]        eff_ipl,
   output logic              user_irq_dis
);
   localparam int EFF_W = PRIO_W + 1;

   if (SR_W != 16 || EFF_W != 4) begin : g_bad_layout
      $error("cpu_status_reg: status layout must be 16 bits with a 3-bit priority");
   end

   logic wr_lo, wr_hi;
   assign wr_lo = bus_wr_en & bus_byte_en[0];
   assign wr_hi = bus_wr_en & bus_byte_en[1];

   logic [NUM_ACC-1:0] ovf_evt, sat_evt, ovf_q, sat_q;
   assign ovf_evt = {acc_ovf_b, acc_ovf_a};
   assign sat_evt = {acc_sat_b, acc_sat_a};

   for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
      sr_sticky_bit #(.SW_CAN_SET(1'b0), .EVENT_WINS(1'b1)) u_ovf (
         .clk (clk),
         .rst_n (rst_n),
         .evt (ovf_evt[i]),
         .wr  (wr_hi),
         .wval(bus_wdata[BIT_OVF_A - i]),
         .q   (ovf_q[i])
      );
      sr_sticky_bit #(.SW_CAN_SET(1'b1), .EVENT_WINS(SAT_EVENT_WINS)) u_sat (
         .clk (clk),
         .rst_n (rst_n),
         .evt (sat_evt[i]),
         .wr  (wr_hi),
         .wval(bus_wdata[BIT_SAT_A - i] & bus_wdata[BIT_SAT_ANY]),
         .q   (sat_q[i])
      );
   end

   logic hc_calc;
   sr_half_carry #(.DATA_W(DATA_W)) u_hc (
      .op_a   (alu_op_a),
      .op_b   (alu_op_b),
      .cin    (alu_cin),
      .byte_op(alu_byte_op),
      .hc     (hc_calc)
   );

   alu_flags_t         flags_q;
   logic               hc_q, loop_q, rpt_q;
   logic [PRIO_W-1:0]  prio_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         hc_q    <= 1'b0;
         loop_q  <= 1'b0;
         rpt_q   <= 1'b0;
         prio_q  <= '0;
      end else begin
         loop_q <= loop_do_active;
         rpt_q  <= loop_rpt_active;
         if (wr_lo)           flags_q <= alu_flags_t'(bus_wdata[FLAG_W-1:0]);
         else if (alu_upd_en) flags_q <= '{neg: alu_n, ovf: alu_ov, zero: alu_z, carry: alu_c};
         if (wr_hi)           hc_q <= bus_wdata[BIT_HCARRY];
         else if (alu_upd_en) hc_q <= hc_calc;
         if (wr_lo && !nest_dis) prio_q <= bus_wdata[BIT_PRIO_LO +: PRIO_W];
      end
   end

   assign sr_value = {ovf_q[0], ovf_q[1], sat_q[0], sat_q[1],
                      |ovf_q, |sat_q, loop_q, hc_q,
                      prio_q, rpt_q, flags_q};
   assign eff_ipl      = {ipl_msb, prio_q};
   assign user_irq_dis = ipl_msb;

   logic unused_wd;
   assign unused_wd = ^{bus_wdata[BIT_OVF_ANY], bus_wdata[BIT_LOOP], bus_wdata[BIT_RPT]};

   // R10: priority frozen while nesting is disabled
   a_r10_prio_locked: assert property (@(posedge clk) disable iff (!rst_n)
      nest_dis |=> $stable(prio_q));
   // R9: status mirrors loop inputs one cycle later
   a_r9_loop_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sr_value[BIT_LOOP] == $past(loop_do_active)) &&
               (sr_value[BIT_RPT] == $past(loop_rpt_active)));
   // R2: ALU flags hold with no source active
   a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!alu_upd_en && !wr_lo) |=> $stable(sr_value[FLAG_W-1:0]));
   // R12: a low-byte write wins over an ALU update
   a_r12_bus_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> sr_value[FLAG_W-1:0] == $past(bus_wdata[FLAG_W-1:0]));
endmodule

// File: tb/cpu_status_reg_tb.sv
module cpu_status_reg_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alu_upd_en = 0, alu_c = 0, alu_z = 0, alu_ov = 0, alu_n = 0;
   logic [15:0] alu_op_a = '0, alu_op_b = '0;
   logic alu_cin = 0, alu_byte_op = 0;
   logic acc_ovf_a = 0, acc_ovf_b = 0, acc_sat_a = 0, acc_sat_b = 0;
   logic loop_do_active = 0, loop_rpt_active = 0;
   logic bus_wr_en = 0;
   logic [1:0] bus_byte_en = '0;
   logic [15:0] bus_wdata = '0;
   logic nest_dis = 0, ipl_msb = 0;
   logic [15:0] sr_value;
   logic [3:0] eff_ipl;
   logic user_irq_dis;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cpu_status_reg #(.DATA_W(16), .SAT_EVENT_WINS(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .alu_upd_en(alu_upd_en), .alu_c(alu_c), .alu_z(alu_z), .alu_ov(alu_ov), .alu_n(alu_n),
      .alu_op_a(alu_op_a), .alu_op_b(alu_op_b), .alu_cin(alu_cin), .alu_byte_op(alu_byte_op),
      .acc_ovf_a(acc_ovf_a), .acc_ovf_b(acc_ovf_b), .acc_sat_a(acc_sat_a), .acc_sat_b(acc_sat_b),
      .loop_do_active(loop_do_active), .loop_rpt_active(loop_rpt_active),
      .bus_wr_en(bus_wr_en), .bus_byte_en(bus_byte_en), .bus_wdata(bus_wdata),
      .nest_dis(nest_dis), .ipl_msb(ipl_msb),
      .sr_value(sr_value), .eff_ipl(eff_ipl), .user_irq_dis(user_irq_dis)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      alu_upd_en = 0; bus_wr_en = 0; bus_byte_en = 2'b00;
      acc_ovf_a = 0; acc_ovf_b = 0; acc_sat_a = 0; acc_sat_b = 0;
   endtask

   task automatic bus_wr(input logic [1:0] be, input logic [15:0] d);
      bus_wr_en = 1; bus_byte_en = be; bus_wdata = d;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         summary();
      end
   end

   initial begin
      ipl_msb = 1;
      repeat (3) step();
      // R1 reset state
      chk("R1 sr_value", sr_value, 16'h0000);
      chk("R1 eff_ipl", {12'h0, eff_ipl}, 16'h0008);
      rst_n = 1;
      step();
      chk("R1 after release", sr_value, 16'h0000);
      ipl_msb = 0;

      // R2 all flag patterns, then hold
      for (int v = 0; v < 16; v++) begin
         alu_upd_en = 1; {alu_n, alu_ov, alu_z, alu_c} = 4'(v);
         step();
         chk("R2 flags load", {12'h0, sr_value[3:0]}, 16'(v));
         alu_upd_en = 0; {alu_n, alu_ov, alu_z, alu_c} = ~4'(v);
         step();
         chk("R2 flags hold", {12'h0, sr_value[3:0]}, 16'(v));
      end

      // R3 byte operations: full low-nibble sweep, junk above
      alu_upd_en = 1; alu_byte_op = 1;
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            for (int ci = 0; ci < 2; ci++) begin
               alu_op_a = {12'(a * 37 + 5), 4'(a)};
               alu_op_b = {12'(b * 91 + 3), 4'(b)};
               alu_cin = ci[0];
               step();
               chk("R3 byte half carry", {15'h0, sr_value[8]}, 16'((a + b + ci) >> 4));
            end
      // R3 word operations: dense low-byte sweep, junk above
      alu_byte_op = 0;
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b += 5) begin
            alu_op_a = {8'(a * 7 + 1), 8'(a)};
            alu_op_b = {8'(b * 13 + 9), 8'(b)};
            alu_cin = 1'((a ^ b) & 1);
            step();
            chk("R3 word half carry", {15'h0, sr_value[8]},
                16'((a + b + ((a ^ b) & 1)) >> 8));
         end
      idle();
      bus_wr(2'b11, 16'h0000); step(); idle();
      chk("R12 word write clears", sr_value, 16'h0000);

      // R4 overflow set by event, summary follows (R8)
      acc_ovf_a = 1; step(); idle(); step();
      chk("R4 ovf A set", {8'h0, sr_value[15:8]}, 16'h0088);
      // clear OA; written 1 on OB must not set it; SA/SB set with bit 10
      bus_wr(2'b10, 16'h7C00); step(); idle();
      chk("R4 ovf clear and no set / R5 sat write", {8'h0, sr_value[15:8]}, 16'h0034);
      // R7 overflow event with clearing write; sat cleared by the same write (R6)
      acc_ovf_b = 1; bus_wr(2'b10, 16'h0000); step(); idle();
      chk("R7 ovf event wins", {8'h0, sr_value[15:8]}, 16'h0048);

      // R5 sticky saturation
      acc_sat_a = 1; step(); idle();
      for (int k = 0; k < 3; k++) begin
         step();
         chk("R5 sat sticky hold", {8'h0, sr_value[15:8]}, 16'h006C);
      end
      // R6 bit 10 written 0 clears both, even with bit 13 written 1
      bus_wr(2'b10, 16'h3000); step(); idle();
      chk("R6 summary clear", {8'h0, sr_value[15:8]}, 16'h0000);
      bus_wr(2'b10, 16'h3400); step(); idle();
      chk("R5 both written set", {8'h0, sr_value[15:8]}, 16'h0034);
      bus_wr(2'b10, 16'h1400); step(); idle();
      chk("R5 only B kept, R8 summary", {8'h0, sr_value[15:8]}, 16'h0014);
      acc_sat_a = 1; bus_wr(2'b10, 16'h0000); step(); idle();
      chk("R7 sat event wins", {8'h0, sr_value[15:8]}, 16'h0024);
      bus_wr(2'b10, 16'h0000); step(); idle();
      chk("R6 clear all", {8'h0, sr_value[15:8]}, 16'h0000);

      // R9 read-only loop status
      loop_do_active = 1; loop_rpt_active = 1;
      bus_wr(2'b11, 16'h0000); step(); idle();
      chk("R9 loop bits set", {14'h0, sr_value[9], sr_value[4]}, 16'h0003);
      loop_do_active = 0; loop_rpt_active = 0;
      bus_wr(2'b11, 16'hFFFF); step(); idle();
      chk("R9 loop bits ignore write", {14'h0, sr_value[9], sr_value[4]}, 16'h0000);
      bus_wr(2'b11, 16'h0000); step(); idle();

      // R10 and R11 priority sweep
      nest_dis = 0;
      for (int v = 0; v < 8; v++)
         for (int m = 0; m < 2; m++) begin
            ipl_msb = m[0];
            bus_wr(2'b01, {8'h00, 3'(v), 5'h00}); step(); idle();
            chk("R10 prio write", {13'h0, sr_value[7:5]}, 16'(v));
            chk("R11 eff_ipl", {12'h0, eff_ipl}, 16'(m * 8 + v));
            chk("R11 user_irq_dis", {15'h0, user_irq_dis}, 16'(m));
         end
      ipl_msb = 0; #1;
      chk("R11 eff_ipl same cycle", {12'h0, eff_ipl}, 16'h0007);
      nest_dis = 1;
      bus_wr(2'b01, 16'h0000); step(); idle();
      chk("R10 prio locked", {13'h0, sr_value[7:5]}, 16'h0007);
      nest_dis = 0;
      bus_wr(2'b01, 16'h0040); step(); idle();
      chk("R10 prio unlocked", {13'h0, sr_value[7:5]}, 16'h0002);

      // R12 bus beats ALU, byte lanes independent
      alu_upd_en = 1; {alu_n, alu_ov, alu_z, alu_c} = 4'hF;
      alu_byte_op = 0; alu_op_a = 16'h00FF; alu_op_b = 16'h0001; alu_cin = 0;
      bus_wr(2'b11, 16'h0000); step(); idle();
      chk("R12 low flags bus wins", {12'h0, sr_value[3:0]}, 16'h0000);
      chk("R12 half carry bus wins", {15'h0, sr_value[8]}, 16'h0000);
      alu_upd_en = 1; step(); idle();
      chk("R12 ALU after write", {7'h0, sr_value[8], 4'h0, sr_value[3:0]}, 16'h010F);
      bus_wr(2'b10, 16'h0000); step(); idle();
      chk("R12 high write keeps low", {7'h0, sr_value[8], 4'h0, sr_value[3:0]}, 16'h000F);
      bus_wr(2'b01, 16'h0105); step(); idle();
      chk("R12 low write keeps high", {7'h0, sr_value[8], 4'h0, sr_value[3:0]}, 16'h0005);

      done = 1;
      summary();
   end
endmodule